// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder, in unsigned or two's-complement signed arithmetic. It works one step per enabled clock: a setup step that strips the operand signs and screens for overflow, seventeen add-or-subtract steps on a partial remainder, and a closing step that corrects the remainder and applies the result signs.

A host pulses `start_i` with the operands on the inputs; the block captures them in that same edge and raises `busy_o`. The host may hold `step_en_i` low on any cycle. The whole iteration state then stays frozen in registers and continues unchanged once the enable returns, so a division can be interleaved with other work at any cycle boundary. Completion is marked by a single-cycle `done_o`. The quotient, remainder and overflow flag are updated with that pulse and then held.

Top module: `idiv_top`

## Requirements
- R1: In unsigned mode (`signed_i`=0, `long_i`=1) the quotient and remainder satisfy dividend = quotient*divisor + remainder with remainder < divisor, whenever the quotient fits in 16 bits.
- R2: With `long_i`=0 only `dividend_i[15:0]` is used: zero-extended when `signed_i`=0, sign-extended from bit 15 when `signed_i`=1; `dividend_i[31:16]` has no effect.
- R3: In signed mode (`signed_i`=1) operands are two's complement, the quotient is truncated toward zero and a non-zero remainder carries the sign of the dividend.
- R4: `done_o` is high in the cycle after the 19th clock edge with `step_en_i`=1 that follows the edge accepting `start_i`; the accepting edge itself does not count.
- R5: While `step_en_i` is 0 the division makes no progress, and any pattern of pauses leaves the result unchanged.
- R6: `busy_o` is high from the cycle after the accepting edge until `done_o` rises; `done_o` is high for exactly one cycle and `busy_o` is low while it is high.
- R7: `ovf_o` is 1 at `done_o` when the divisor is zero or the quotient is out of range (above 65535 unsigned; outside -32768..32767 signed); quotient and remainder are then unspecified.
- R8: A `start_i` pulse while `busy_o` is high is ignored: neither the running division nor its operands change, and it produces no extra `done_o`.
- R9: After reset all outputs are 0; quotient, remainder and `ovf_o` change only in the cycle where `done_o` is high and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a division; accepted only while idle |
| step_en_i | input | 1 | Advance one step on this edge; 0 pauses |
| long_i | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| signed_i | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend_i | input | 32 | Dividend, sampled on the accepting edge |
| divisor_i | input | 16 | Divisor, sampled on the accepting edge |
| quotient_o | output | 16 | Quotient of the last division |
| remainder_o | output | 16 | Remainder of the last division |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Divide by zero or quotient out of range |

## Verification
The bench uses the package defaults: a 16-bit divisor and quotient and a 32-bit dividend, which makes seventeen iterations and a 19-step latency. At this size the true extremes can be driven directly: a 0xFFFF divisor with the largest quotient that still fits, the most negative dividend and divisor, -32768 quotients that sit exactly on the signed limit, and 16-bit operands carrying unrelated upper bits. Pauses come as alternating, pseudo-random and long initial stalls, which exercises the freeze at every phase of the iteration.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

    localparam int DW  = 16;            // divisor, quotient and remainder width
    localparam int XW  = 2 * DW;        // long dividend width
    localparam int QW  = DW + 1;        // iteration count and quotient magnitude bits
    localparam int RW  = DW + 2;        // signed partial remainder width
    localparam int LAT = QW + 2;        // enabled steps from accept to done
    localparam int CW  = $clog2(QW);
    localparam int LW  = $clog2(LAT + 1);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ITER,
        PH_FIX
    } phase_e;

    typedef struct packed {
        logic          lng;
        logic          sgn;
        logic [XW-1:0] dvd;
        logic [DW-1:0] dvs;
    } op_t;

    typedef struct packed {
        logic          q_neg;
        logic          r_neg;
        logic          sgn;
        logic          pre_ovf;
        logic [DW-1:0] dvs_mag;
    } prep_t;

    typedef struct packed {
        logic [DW-1:0] quo;
        logic [DW-1:0] rem;
        logic          ovf;
    } res_t;

    // Dividend as a full-width value after the short/long and sign selection.
    function automatic logic [XW-1:0] widen_dvd(op_t op);
        logic [DW-1:0] lo;
        lo = op.dvd[DW-1:0];
        if (op.lng)
            return op.dvd;
        else if (op.sgn)
            return {{DW{lo[DW-1]}}, lo};
        else
            return {{DW{1'b0}}, lo};
    endfunction

    function automatic logic [XW-1:0] mag_x(logic [XW-1:0] v, logic neg);
        return neg ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [DW-1:0] mag_d(logic [DW-1:0] v, logic neg);
        return neg ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/idiv_prep.sv
module idiv_prep
    import idiv_pkg::*;
(
    input  op_t           op_i,
    output prep_t         prep_o,
    output logic [RW-1:0] rem_init_o,
    output logic [QW-1:0] work_init_o
);

    logic [XW-1:0] dvd_ext;
    logic [XW-1:0] dvd_mag;
    logic [DW-1:0] hi;
    logic          dvd_neg;
    logic          dvs_neg;

    always_comb begin
        dvd_ext = widen_dvd(op_i);
        dvd_neg = op_i.sgn & dvd_ext[XW-1];
        dvs_neg = op_i.sgn & op_i.dvs[DW-1];
        dvd_mag = mag_x(dvd_ext, dvd_neg);
        hi      = dvd_mag[XW-1:DW];

        prep_o.q_neg   = dvd_neg ^ dvs_neg;
        prep_o.r_neg   = dvd_neg;
        prep_o.sgn     = op_i.sgn;
        prep_o.dvs_mag = mag_d(op_i.dvs, dvs_neg);
        // Upper half not below the divisor: magnitude quotient needs more
        // than DW bits, and a zero divisor always lands here.
        prep_o.pre_ovf = (hi >= prep_o.dvs_mag);

        // The upper half minus its last bit seeds the remainder; the iteration
        // then consumes that bit and the lower half, QW bits in all.
        rem_init_o  = {{(RW-DW+1){1'b0}}, hi[DW-1:1]};
        work_init_o = {hi[0], dvd_mag[DW-1:0]};
    end

endmodule

// File: rtl/idiv_step.sv
module idiv_step
    import idiv_pkg::*;
(
    input  logic [RW-1:0] rem_i,
    input  logic [QW-1:0] work_i,
    input  logic [DW-1:0] dvs_mag_i,
    output logic [RW-1:0] rem_o,
    output logic [QW-1:0] work_o
);

    logic [RW-1:0] shifted;
    logic [RW-1:0] dvs_ext;

    always_comb begin
        shifted = {rem_i[RW-2:0], work_i[QW-1]};
        dvs_ext = {{(RW-DW){1'b0}}, dvs_mag_i};
        // Non-restoring: subtract on a non-negative remainder, add otherwise.
        if (rem_i[RW-1])
            rem_o = shifted + dvs_ext;
        else
            rem_o = shifted - dvs_ext;
        work_o = {work_i[QW-2:0], ~rem_o[RW-1]};
    end

endmodule

// File: rtl/idiv_fix.sv
module idiv_fix
    import idiv_pkg::*;
(
    input  logic [RW-1:0] rem_i,
    input  logic [QW-1:0] qmag_i,
    input  prep_t         prep_i,
    output res_t          res_o
);

    logic [RW-1:0] rem_fin;
    logic [QW-1:0] lim;
    logic          range_bad;

    always_comb begin
        if (rem_i[RW-1])
            rem_fin = rem_i + {{(RW-DW){1'b0}}, prep_i.dvs_mag};
        else
            rem_fin = rem_i;

        lim = QW'(2 ** (DW - 1)) - QW'(!prep_i.q_neg);
        if (prep_i.sgn)
            range_bad = (qmag_i > lim);
        else
            range_bad = qmag_i[QW-1];

        res_o.quo = mag_d(qmag_i[DW-1:0], prep_i.q_neg);
        res_o.rem = mag_d(rem_fin[DW-1:0], prep_i.r_neg);
        res_o.ovf = prep_i.pre_ovf | range_bad;
    end

endmodule

// File: rtl/idiv_ctrl.sv
module idiv_ctrl
    import idiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic step_en_i,
    output logic accept_o,
    output logic setup_o,
    output logic iter_o,
    output logic fix_o,
    output logic busy_o,
    output logic done_o
);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          adv;

    always_comb begin
        accept_o = start_i && (phase_q == PH_IDLE);
        adv      = step_en_i && (phase_q != PH_IDLE);
        setup_o  = adv && (phase_q == PH_SETUP);
        iter_o   = adv && (phase_q == PH_ITER);
        fix_o    = adv && (phase_q == PH_FIX);
        busy_o   = (phase_q != PH_IDLE);
        done_o   = done_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fix_o;
            unique case (phase_q)
                PH_IDLE:  if (accept_o) phase_q <= PH_SETUP;
                PH_SETUP: if (adv) begin
                    phase_q <= PH_ITER;
                    cnt_q   <= '0;
                end
                PH_ITER:  if (adv) begin
                    if (cnt_q == CW'(QW - 1))
                        phase_q <= PH_FIX;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                PH_FIX:   if (adv) phase_q <= PH_IDLE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // R6: completion marker lasts a single cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6: busy is released no later than the completion pulse
    a_r6_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R6: a running division ends only through done
    a_r6_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o));

    // R5, R8: a withheld enable freezes sequencing, whatever start does
    a_r5_freeze_seq: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !step_en_i) |=> ($stable(phase_q) && $stable(cnt_q) && !done_o));

endmodule

// File: rtl/idiv_top.sv
module idiv_top
    import idiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          step_en_i,
    input  logic          long_i,
    input  logic          signed_i,
    input  logic [XW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic [DW-1:0] quotient_o,
    output logic [DW-1:0] remainder_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          ovf_o
);

    logic accept, do_setup, do_iter, do_fix;

    op_t           op_q;
    prep_t         prep_q, prep_d;
    logic [RW-1:0] rem_q, rem_init, rem_next;
    logic [QW-1:0] work_q, work_init, work_next;
    res_t          res_q, res_d;

    idiv_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .step_en_i (step_en_i),
        .accept_o  (accept),
        .setup_o   (do_setup),
        .iter_o    (do_iter),
        .fix_o     (do_fix),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    idiv_prep u_prep (
        .op_i        (op_q),
        .prep_o      (prep_d),
        .rem_init_o  (rem_init),
        .work_init_o (work_init)
    );

    idiv_step u_step (
        .rem_i     (rem_q),
        .work_i    (work_q),
        .dvs_mag_i (prep_q.dvs_mag),
        .rem_o     (rem_next),
        .work_o    (work_next)
    );

    idiv_fix u_fix (
        .rem_i  (rem_q),
        .qmag_i (work_q),
        .prep_i (prep_q),
        .res_o  (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            prep_q <= '0;
            rem_q  <= '0;
            work_q <= '0;
            res_q  <= '0;
        end else begin
            if (accept) begin
                op_q.lng <= long_i;
                op_q.sgn <= signed_i;
                op_q.dvd <= dividend_i;
                op_q.dvs <= divisor_i;
            end
            if (do_setup) begin
                prep_q <= prep_d;
                rem_q  <= rem_init;
                work_q <= work_init;
            end else if (do_iter) begin
                rem_q  <= rem_next;
                work_q <= work_next;
            end
            if (do_fix)
                res_q <= res_d;
        end
    end

    assign quotient_o  = res_q.quo;
    assign remainder_o = res_q.rem;
    assign ovf_o       = res_q.ovf;

    // Checking aids: enabled steps since acceptance, effective dividend and
    // its sign, and the reconstructed unsigned product.
    logic [LW-1:0] lat_cnt;
    logic [XW-1:0] eff_dvd;
    logic [XW-1:0] rebuilt;
    logic          dvd_sign;

    always_ff @(posedge clk) begin
        if (rst || accept)
            lat_cnt <= '0;
        else if (busy_o && step_en_i && lat_cnt != LW'(LAT))
            lat_cnt <= lat_cnt + 1'b1;
    end

    always_comb begin
        eff_dvd  = widen_dvd(op_q);
        dvd_sign = eff_dvd[XW-1];
        rebuilt  = XW'(quotient_o) * XW'(op_q.dvs) + XW'(remainder_o);
    end

    // R4: fixed latency counted in enabled steps
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_cnt == LW'(LAT)));

    // R1, R2: unsigned result rebuilds the effective dividend
    a_r1_unsigned_identity: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ovf_o && !op_q.sgn) |->
            ((rebuilt == eff_dvd) && (remainder_o < op_q.dvs)));

    // R3: a non-zero signed remainder follows the dividend's sign
    a_r3_rem_sign: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ovf_o && op_q.sgn && remainder_o != '0) |->
            (remainder_o[DW-1] == dvd_sign));

    // R7: a zero divisor is always flagged
    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q.dvs == '0) |-> ovf_o);

    // R9: results move only together with the completion pulse
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(ovf_o)));

    // R5: partial remainder and quotient bits are frozen while paused
    a_r5_freeze_data: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !step_en_i) |=> ($stable(rem_q) && $stable(work_q)));

    // R8: captured operands stay put for the whole division
    a_r8_operands_kept: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o ? $stable(op_q) : 1'b1));

endmodule

// File: tb/idiv_top_tb.sv
module idiv_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        step_en = 1'b0;
    logic        lng = 1'b0;
    logic        sgn = 1'b0;
    logic [31:0] dvd = '0;
    logic [15:0] dvs = '0;
    logic [15:0] quo, rem;
    logic        busy, done, ovf;

    always #10 clk = ~clk;

    idiv_top u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .step_en_i   (step_en),
        .long_i      (lng),
        .signed_i    (sgn),
        .dividend_i  (dvd),
        .divisor_i   (dvs),
        .quotient_o  (quo),
        .remainder_o (rem),
        .busy_o      (busy),
        .done_o      (done),
        .ovf_o       (ovf)
    );

    typedef struct {
        logic [15:0] q;
        logic [15:0] r;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    int         total = 0;
    int         bad = 0;
    int         en_cnt = 0;
    bit         ended = 0;
    logic       prev_done = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] a, input logic [15:0] b,
                                   input logic l, input logic s, input string tag);
        exp_t   e;
        longint x, y, q, r;
        if (s) begin
            x = l ? longint'($signed(a)) : longint'($signed(a[15:0]));
            y = longint'($signed(b));
        end else begin
            x = l ? longint'({32'b0, a}) : longint'({48'b0, a[15:0]});
            y = longint'({48'b0, b});
        end
        e.tag = tag;
        if (y == 0) begin
            e.ovf = 1'b1;
            e.q = '0;
            e.r = '0;
        end else begin
            q = x / y;
            r = x % y;
            e.ovf = s ? (q > 32767 || q < -32768) : (q > 65535);
            e.q = q[15:0];
            e.r = r[15:0];
        end
        return e;
    endfunction

    // Enabled steps since the accepting edge (R4).
    always @(posedge clk) begin
        if (rst)
            en_cnt <= 0;
        else if (start && !busy)
            en_cnt <= 0;
        else if (busy && step_en)
            en_cnt <= en_cnt + 1;
    end

    // Monitor: pops the scoreboard on every completion pulse.
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            chk("R6", "done longer than one cycle", prev_done, 0);
            chk("R6", "busy while done", busy, 0);
            if (sb.size() == 0) begin
                chk("R8", "unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                chk("R4", "enabled steps to done", en_cnt, 19);
                chk("R7", {"overflow flag for ", e.tag}, ovf, e.ovf);
                if (!e.ovf) begin
                    chk(e.tag, "quotient", quo, e.q);
                    chk(e.tag, "remainder", rem, e.r);
                end
            end
        end
        prev_done <= done;
    end

    // Driver: mode 0 steady enable, 1 alternating, 2 pseudo-random, 3 long stall first.
    task automatic run(input logic [31:0] a, input logic [15:0] b, input logic l,
                       input logic s, input int mode, input bit inject, input string tag);
        int k;
        sb.push_back(model(a, b, l, s, tag));
        @(negedge clk);
        dvd = a; dvs = b; lng = l; sgn = s;
        start = 1'b1;
        step_en = (mode == 0);
        @(negedge clk);
        start = 1'b0;
        chk("R6", "busy after accept", busy, 1);
        k = 0;
        while (!done) begin
            case (mode)
                0: step_en = 1'b1;
                1: step_en = k[0];
                2: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    step_en = lfsr[0];
                end
                default: step_en = (k >= 8);
            endcase
            if (inject && (k == 3 || k == 11)) begin
                start = 1'b1;
                dvd = ~a; dvs = b + 16'd3; lng = ~l; sgn = ~s;
            end else begin
                start = 1'b0;
            end
            k++;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        logic [15:0] hq, hr;
        logic        ho;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9", "busy after reset", busy, 0);
        chk("R9", "done after reset", done, 0);
        chk("R9", "quotient after reset", quo, 0);
        chk("R9", "remainder after reset", rem, 0);
        chk("R9", "ovf after reset", ovf, 0);

        run(32'd100000,     16'd7,      1, 0, 0, 0, "R1");
        run(32'hFFFE_0001,  16'hFFFF,   1, 0, 1, 0, "R1");
        run(32'hFFFE_FFFF,  16'hFFFF,   1, 0, 0, 0, "R1");
        run(32'h0001_0000,  16'd1,      1, 0, 0, 0, "R7");
        run(32'd1234,       16'd0,      1, 0, 2, 0, "R7");
        run(32'hABCD_1234,  16'h0010,   0, 0, 2, 0, "R2");
        run(32'hDEAD_FFFF,  16'd1,      0, 0, 0, 0, "R2");
        run(32'hDEAD_FFF9,  16'd2,      0, 1, 1, 0, "R2");
        run(-32'sd100000,   16'd7,      1, 1, 3, 0, "R3");
        run(32'd100000,     -16'sd7,    1, 1, 0, 0, "R3");
        run(-32'sd100000,   -16'sd7,    1, 1, 2, 0, "R3");
        run(32'd1000,       16'h8000,   1, 1, 0, 0, "R3");
        run(32'h8000_0000,  16'hFFFF,   1, 1, 0, 0, "R7");
        run(32'h0000_8000,  16'hFFFF,   0, 1, 1, 0, "R7");
        run(-32'sd65536,    16'd2,      1, 1, 0, 0, "R7");
        run(32'd65536,      16'd2,      1, 1, 0, 0, "R7");
        run(32'd77,         16'd0,      0, 1, 0, 0, "R7");
        run(-32'sd12345678, -16'sd1234, 1, 1, 2, 0, "R5");
        run(32'd123456789,  16'd4321,   1, 0, 3, 0, "R5");
        run(32'd100000,     16'd7,      1, 0, 1, 1, "R8");
        run(-32'sd9999,     16'd100,    1, 1, 2, 1, "R8");

        // R9: results hold with enable and stray inputs moving, no start
        @(negedge clk);
        hq = quo; hr = rem; ho = ovf;
        for (int i = 0; i < 12; i++) begin
            step_en = i[0];
            dvd = dvd + 32'd17;
            @(negedge clk);
        end
        chk("R9", "quotient held", quo, hq);
        chk("R9", "remainder held", rem, hr);
        chk("R9", "ovf held", ovf, ho);

        repeat (40) @(negedge clk);
        chk("R4", "results still pending", sb.size(), 0);
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule